// File: doc/BRIEF.md
# Context-Tagged Set-Associative Translation Buffer

This block caches virtual-to-physical page translations in a set-associative array. Each cached entry holds a physical frame number and its protection bits. Each entry also carries a 12-bit address-space context tag and a global flag. Because entries carry their context, the block can move between address spaces without emptying the array. Entries of an inactive context stay resident and hit again once that context is current.

Lookups arrive on a valid/ready stream and return a hit or miss response one cycle later on a second valid/ready stream. The request side is ready whenever the response register is empty or is being drained in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response that is not taken stays on the port unchanged.

The other inputs are plain single-cycle strobes:
- Fills come from an external page-table walker.
- Context loads carry the low 12 bits of the new page-table base value.
- Invalidate commands target one page, one context, or the whole array.

Top module: `ctx_tlb`

## Requirements
- R1: An accepted lookup whose VPN matches a valid entry tagged with the current context produces, on the next cycle, `rsp_valid=1`, `rsp_hit=1`, `rsp_miss=0` and that entry's PFN and protection bits.
- R2: An accepted lookup with no matching entry produces, on the next cycle, `rsp_valid=1`, `rsp_hit=0`, `rsp_miss=1`, with `rsp_pfn` and `rsp_prot` both zero.
- R3: A non-global entry hits only while its context tag equals the current context. A global entry (`fill_global=1` at fill) hits under any context.
- R4: A `ctx_load` strobe makes `ctx_sel` the current context. With `ctx_keep=0` it also removes every non-global entry and keeps global ones. With `ctx_keep=1` no entry is removed. After reset the current context is 0.
- R5: The invalidate command with `inv_op=2'b01` removes every non-global entry whose context tag equals `inv_ctx`. Global entries and entries of other contexts remain.
- R6: The invalidate command with `inv_op=2'b00` removes the entry whose VPN equals `inv_vpn` and which is either tagged with `inv_ctx` or global. Other pages remain.
- R7: The invalidate command with `inv_op=2'b10` removes every entry, global ones included. The code `inv_op=2'b11` has no effect on the array.
- R8: The set index is the low log2(SETS) bits of the VPN, and the rest of the VPN is the tag. A fill works in this order:
  - It rewrites the way already holding the same VPN visible to the current context.
  - Otherwise it takes the lowest-numbered invalid way of the set.
  - Otherwise it takes the way named by that set's round-robin pointer, which starts at way 0 and then advances by one with wrap.
  - The pointer moves only on such an eviction.
- R9: An invalidate or context load in the same cycle as an accepted lookup takes effect before that lookup is evaluated. The lookup uses the new context. A fill in the same cycle is not seen by that lookup.
- R10: While `rsp_valid=1` and `rsp_ready=0`, `req_ready` is 0 and the response fields hold their values. A new request is accepted in the cycle the response is drained.
- R11: After reset the array is empty, `rsp_valid=0` and `req_ready=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_pfn | output | PFN_W | Physical frame number, zero on miss |
| rsp_prot | output | PROT_W | Protection bits, zero on miss |
| ctx_load | input | 1 | Page-table base load strobe |
| ctx_keep | input | 1 | Keep non-global entries on this load |
| ctx_sel | input | 12 | Low 12 bits of the new base value (new context) |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | VPN of the new translation |
| fill_pfn | input | PFN_W | PFN of the new translation |
| fill_prot | input | PROT_W | Protection bits of the new translation |
| fill_global | input | 1 | New translation is global |
| inv_en | input | 1 | Invalidate command strobe |
| inv_op | input | 2 | 00 page, 01 context, 10 all, 11 none |
| inv_vpn | input | VPN_W | Page for a page invalidate |
| inv_ctx | input | 12 | Context for page and context invalidates |

## Verification
Most internal faults reach the ports on the very next response. A lost global flag shows as a miss right after a flushing context load. A wrong context compare shows as a stale hit after a switch or an invalidate. A replacement pointer that moves on the wrong condition stays hidden until the set fills. It then surfaces as the wrong victim missing on the lookups after the fifth and sixth fills to one set. The stimulus therefore fills one set past capacity and probes every resident page.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int CTX_W = 12;
  localparam logic [1:0] OP_PAGE = 2'b00;
  localparam logic [1:0] OP_CTX  = 2'b01;
  localparam logic [1:0] OP_ALL  = 2'b10;
  localparam logic [1:0] OP_NONE = 2'b11;
endpackage

// File: rtl/xlat_array.sv
module xlat_array
  import xlat_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 16,
  parameter int PFN_W  = 20,
  parameter int PROT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inv_en,
  input  logic [1:0]           inv_op,
  input  logic [IDX_W-1:0]     inv_idx,
  input  logic [TAG_W-1:0]     inv_tag,
  input  logic [CTX_W-1:0]     inv_ctx,
  input  logic                 flush_ng,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [WAYS-1:0]      fill_way,
  input  logic [TAG_W-1:0]     fill_tag,
  input  logic [CTX_W-1:0]     fill_ctx,
  input  logic                 fill_glob,
  input  logic [PFN_W-1:0]     fill_pfn,
  input  logic [PROT_W-1:0]    fill_prot,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [WAYS-1:0]      rd_live,
  output logic [WAYS-1:0]      rd_glob,
  output logic [TAG_W-1:0]     rd_tag  [WAYS],
  output logic [CTX_W-1:0]     rd_ctx  [WAYS],
  output logic [PFN_W-1:0]     rd_pfn  [WAYS],
  output logic [PROT_W-1:0]    rd_prot [WAYS],
  output logic [WAYS-1:0]      fl_live,
  output logic [WAYS-1:0]      fl_glob,
  output logic [TAG_W-1:0]     fl_tag  [WAYS],
  output logic [CTX_W-1:0]     fl_ctx  [WAYS]
);
  localparam int ENTRIES = SETS * WAYS;

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   glb_q  [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [CTX_W-1:0]  ctx_q  [SETS][WAYS];
  logic [PFN_W-1:0]  pfn_q  [SETS][WAYS];
  logic [PROT_W-1:0] prot_q [SETS][WAYS];
  logic [WAYS-1:0]   kill   [SETS];
  logic [WAYS-1:0]   live   [SETS];

  // Removal mask for this cycle: commands act before reads and fills.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      kill[s] = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (inv_en) begin
          case (inv_op)
            OP_PAGE: kill[s][w] = (IDX_W'(s) == inv_idx) && (tag_q[s][w] == inv_tag) &&
                                  (glb_q[s][w] || (ctx_q[s][w] == inv_ctx));
            OP_CTX:  kill[s][w] = !glb_q[s][w] && (ctx_q[s][w] == inv_ctx);
            OP_ALL:  kill[s][w] = 1'b1;
            default: kill[s][w] = 1'b0;
          endcase
        end
        if (flush_ng && !glb_q[s][w]) kill[s][w] = 1'b1;
      end
      live[s] = vld_q[s] & ~kill[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        glb_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= live[s];
      if (fill_en) begin
        vld_q[fill_idx] <= live[fill_idx] | fill_way;
        for (int w = 0; w < WAYS; w++)
          if (fill_way[w]) glb_q[fill_idx][w] <= fill_glob;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (fill_way[w]) begin
          tag_q[fill_idx][w]  <= fill_tag;
          ctx_q[fill_idx][w]  <= fill_ctx;
          pfn_q[fill_idx][w]  <= fill_pfn;
          prot_q[fill_idx][w] <= fill_prot;
        end
      end
    end
  end

  always_comb begin
    rd_live = live[rd_idx];
    rd_glob = glb_q[rd_idx];
    fl_live = live[fill_idx];
    fl_glob = glb_q[fill_idx];
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w]  = tag_q[rd_idx][w];
      rd_ctx[w]  = ctx_q[rd_idx][w];
      rd_pfn[w]  = pfn_q[rd_idx][w];
      rd_prot[w] = prot_q[rd_idx][w];
      fl_tag[w]  = tag_q[fill_idx][w];
      fl_ctx[w]  = ctx_q[fill_idx][w];
    end
  end

  logic [ENTRIES-1:0] vld_flat, glb_flat;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_flat[s*WAYS +: WAYS] = vld_q[s];
      glb_flat[s*WAYS +: WAYS] = glb_q[s];
    end
  end

  AST_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_op == OP_ALL && !fill_en) |=> (vld_flat == '0)); // R7

  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_ng && !inv_en && !fill_en) |=> (vld_flat == ($past(vld_flat) & $past(glb_flat)))); // R4
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAYS-1:0]  fl_live,
  input  logic [WAYS-1:0]  fl_hit,
  output logic [WAYS-1:0]  way_oh
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] rr_q [SETS];
  logic             use_rr;

  function automatic logic [WAYS-1:0] lowest(input logic [WAYS-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  always_comb begin
    use_rr = 1'b0;
    if (|fl_hit)        way_oh = lowest(fl_hit);
    else if (~&fl_live) way_oh = lowest(~fl_live);
    else begin
      use_rr = 1'b1;
      way_oh = WAYS'(1) << rr_q[fill_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill_en && use_rr) begin
      rr_q[fill_idx] <= (rr_q[fill_idx] == WAY_W'(WAYS-1)) ? '0 : rr_q[fill_idx] + WAY_W'(1);
    end
  end

  AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> ($countones(way_oh) == 1)); // R8
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 16,
  parameter int PFN_W  = 20,
  parameter int PROT_W = 4
) (
  input  logic [WAYS-1:0]   live,
  input  logic [WAYS-1:0]   glob,
  input  logic [TAG_W-1:0]  tag  [WAYS],
  input  logic [CTX_W-1:0]  ctx  [WAYS],
  input  logic [PFN_W-1:0]  pfn  [WAYS],
  input  logic [PROT_W-1:0] prot [WAYS],
  input  logic [TAG_W-1:0]  key_tag,
  input  logic [CTX_W-1:0]  key_ctx,
  output logic [WAYS-1:0]   hit_vec,
  output logic              hit,
  output logic [PFN_W-1:0]  out_pfn,
  output logic [PROT_W-1:0] out_prot
);
  always_comb begin
    hit_vec  = '0;
    out_pfn  = '0;
    out_prot = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = live[w] && (tag[w] == key_tag) && (glob[w] || (ctx[w] == key_ctx));
      if (hit_vec[w]) begin
        out_pfn  = out_pfn | pfn[w];
        out_prot = out_prot | prot[w];
      end
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import xlat_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PROT_W = 4,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PROT_W-1:0] rsp_prot,
  input  logic              ctx_load,
  input  logic              ctx_keep,
  input  logic [CTX_W-1:0]  ctx_sel,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              fill_global,
  input  logic              inv_en,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [CTX_W-1:0]  inv_ctx
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [CTX_W-1:0] ctx_q, eff_ctx;
  logic             flush_ng, accept;

  assign eff_ctx  = ctx_load ? ctx_sel : ctx_q;
  assign flush_ng = ctx_load && !ctx_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx_q <= '0;
    else        ctx_q <= eff_ctx;
  end

  logic [WAYS-1:0]   rd_live, rd_glob, fl_live, fl_glob, fl_hit, way_oh;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [CTX_W-1:0]  rd_ctx  [WAYS];
  logic [PFN_W-1:0]  rd_pfn  [WAYS];
  logic [PROT_W-1:0] rd_prot [WAYS];
  logic [TAG_W-1:0]  fl_tag  [WAYS];
  logic [CTX_W-1:0]  fl_ctx  [WAYS];

  xlat_array #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PFN_W(PFN_W), .PROT_W(PROT_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .inv_en(inv_en), .inv_op(inv_op),
    .inv_idx(inv_vpn[IDX_W-1:0]), .inv_tag(inv_vpn[VPN_W-1:IDX_W]), .inv_ctx(inv_ctx),
    .flush_ng(flush_ng),
    .fill_en(fill_en), .fill_idx(fill_vpn[IDX_W-1:0]), .fill_way(way_oh),
    .fill_tag(fill_vpn[VPN_W-1:IDX_W]), .fill_ctx(eff_ctx), .fill_glob(fill_global),
    .fill_pfn(fill_pfn), .fill_prot(fill_prot),
    .rd_idx(req_vpn[IDX_W-1:0]),
    .rd_live(rd_live), .rd_glob(rd_glob), .rd_tag(rd_tag), .rd_ctx(rd_ctx),
    .rd_pfn(rd_pfn), .rd_prot(rd_prot),
    .fl_live(fl_live), .fl_glob(fl_glob), .fl_tag(fl_tag), .fl_ctx(fl_ctx)
  );

  // Existing translation for the fill key, seen after this cycle's removals.
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      fl_hit[w] = fl_live[w] && (fl_tag[w] == fill_vpn[VPN_W-1:IDX_W]) &&
                  (fl_glob[w] || (fl_ctx[w] == eff_ctx));
  end

  xlat_victim #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_vpn[IDX_W-1:0]),
    .fl_live(fl_live), .fl_hit(fl_hit), .way_oh(way_oh)
  );

  logic [WAYS-1:0]   look_hitv;
  logic              look_hit;
  logic [PFN_W-1:0]  look_pfn;
  logic [PROT_W-1:0] look_prot;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PFN_W(PFN_W), .PROT_W(PROT_W)) u_look (
    .live(rd_live), .glob(rd_glob), .tag(rd_tag), .ctx(rd_ctx), .pfn(rd_pfn), .prot(rd_prot),
    .key_tag(req_vpn[VPN_W-1:IDX_W]), .key_ctx(eff_ctx),
    .hit_vec(look_hitv), .hit(look_hit), .out_pfn(look_pfn), .out_prot(look_prot)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_miss  = rsp_valid && !rsp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_prot  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= look_hit;
      rsp_pfn   <= look_pfn;
      rsp_prot  <= look_prot;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pfn == '0 && rsp_prot == '0)); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_pfn) && $stable(rsp_prot))); // R10

  AST_INV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && inv_en && inv_op == OP_ALL) |=> rsp_miss); // R9

  AST_UNIQUE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hitv)); // R8
endmodule

// File: tb/sim_ctx_tlb.sv
`timescale 1ns/1ps
module sim_ctx_tlb;
  localparam logic [1:0] F = 2'd0, L = 2'd1, C = 2'd2, I = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [19:0] dat;
    logic [3:0]  prot;
    logic        flag;
    logic        ehit;
    logic [19:0] epfn;
    logic [3:0]  eprot;
    logic [3:0]  rq;
  } vec_t;

  // op F: fill (dat=pfn, flag=global); L: lookup; C: context load (dat=ctx, flag=keep);
  // I: invalidate (prot[1:0]=code, dat=ctx)
  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{C, 20'h00000, 20'h00005, 4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd4},
    '{F, 20'h00010, 20'hAAAAA, 4'h3, 1'b0, 1'b0, 20'h0,     4'h0, 4'd8},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b1, 20'hAAAAA, 4'h3, 4'd1},  // R1
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd2},  // R2
    '{F, 20'h00020, 20'hBBBBB, 4'h1, 1'b1, 1'b0, 20'h0,     4'h0, 4'd8},
    '{C, 20'h00000, 20'h00007, 4'h0, 1'b1, 1'b0, 20'h0,     4'h0, 4'd4},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd3},  // R3
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b1, 20'hBBBBB, 4'h1, 4'd3},  // R3
    '{F, 20'h00010, 20'hCCCCC, 4'h2, 1'b0, 1'b0, 20'h0,     4'h0, 4'd8},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b1, 20'hCCCCC, 4'h2, 4'd1},  // R1
    '{C, 20'h00000, 20'h00005, 4'h0, 1'b1, 1'b0, 20'h0,     4'h0, 4'd4},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b1, 20'hAAAAA, 4'h3, 4'd4},  // R4
    '{I, 20'h00000, 20'h00007, 4'h1, 1'b0, 1'b0, 20'h0,     4'h0, 4'd5},
    '{C, 20'h00000, 20'h00007, 4'h0, 1'b1, 1'b0, 20'h0,     4'h0, 4'd4},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd5},  // R5
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b1, 20'hBBBBB, 4'h1, 4'd5},  // R5
    '{C, 20'h00000, 20'h00005, 4'h0, 1'b1, 1'b0, 20'h0,     4'h0, 4'd4},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b1, 20'hAAAAA, 4'h3, 4'd5},  // R5
    '{I, 20'h00010, 20'h00005, 4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd6},
    '{L, 20'h00010, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd6},  // R6
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b1, 20'hBBBBB, 4'h1, 4'd6},  // R6
    '{F, 20'h00041, 20'hDDDDD, 4'h5, 1'b0, 1'b0, 20'h0,     4'h0, 4'd8},
    '{C, 20'h00000, 20'h00005, 4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd4},
    '{L, 20'h00041, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd4},  // R4
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b1, 20'hBBBBB, 4'h1, 4'd4},  // R4
    '{I, 20'h00020, 20'h00000, 4'h3, 1'b0, 1'b0, 20'h0,     4'h0, 4'd7},
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b1, 20'hBBBBB, 4'h1, 4'd7},  // R7
    '{I, 20'h00020, 20'h00009, 4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd6},
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd6},  // R6
    '{F, 20'h00020, 20'hBBBBB, 4'h1, 1'b1, 1'b0, 20'h0,     4'h0, 4'd8},
    '{I, 20'h00000, 20'h00000, 4'h2, 1'b0, 1'b0, 20'h0,     4'h0, 4'd7},
    '{L, 20'h00020, 20'h0,     4'h0, 1'b0, 1'b0, 20'h0,     4'h0, 4'd7}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_hit, rsp_miss;
  logic [19:0] req_vpn = '0, rsp_pfn, fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
  logic [3:0]  rsp_prot, fill_prot = '0;
  logic ctx_load = 0, ctx_keep = 0, fill_en = 0, fill_global = 0, inv_en = 0;
  logic [11:0] ctx_sel = '0, inv_ctx = '0;
  logic [1:0]  inv_op = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctx_tlb u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot), .ctx_load(ctx_load), .ctx_keep(ctx_keep),
    .ctx_sel(ctx_sel), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_prot(fill_prot), .fill_global(fill_global), .inv_en(inv_en), .inv_op(inv_op),
    .inv_vpn(inv_vpn), .inv_ctx(inv_ctx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = 0; ctx_load = 0; ctx_keep = 0; fill_en = 0; fill_global = 0; inv_en = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_rsp(input string tag, input logic eh, input logic [19:0] ep);
    chk({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " hit"},   {31'b0, rsp_hit},   {31'b0, eh});
    chk({tag, " miss"},  {31'b0, rsp_miss},  {31'b0, !eh});
    chk({tag, " pfn"},   {12'b0, rsp_pfn},   {12'b0, ep});
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_prot = 4'h1; fill_global = 0;
    tick(); clear_in();
  endtask

  task automatic do_look(input string tag, input logic [19:0] v, input logic eh, input logic [19:0] ep);
    req_valid = 1; req_vpn = v;
    tick(); clear_in();
    chk_rsp(tag, eh, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R11 req_ready", {31'b0, req_ready}, 32'd1);
    do_look("R11 empty", 20'h00010, 1'b0, 20'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        F: begin fill_en = 1; fill_vpn = VEC[i].vpn; fill_pfn = VEC[i].dat;
                  fill_prot = VEC[i].prot; fill_global = VEC[i].flag; end
        L: begin req_valid = 1; req_vpn = VEC[i].vpn; end
        C: begin ctx_load = 1; ctx_sel = VEC[i].dat[11:0]; ctx_keep = VEC[i].flag; end
        default: begin inv_en = 1; inv_op = VEC[i].prot[1:0]; inv_vpn = VEC[i].vpn;
                  inv_ctx = VEC[i].dat[11:0]; end
      endcase
      tick(); clear_in();
      if (VEC[i].op == L) begin
        chk_rsp($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].ehit, VEC[i].epfn);
        chk($sformatf("R%0d vec%0d prot", VEC[i].rq, i), {28'b0, rsp_prot}, {28'b0, VEC[i].eprot});
      end
    end

    // R8: set 2, four free ways then round-robin eviction (context 5, array empty)
    for (int k = 0; k < 6; k++) do_fill(20'h00002 + 20'(k * 16), 20'h00102 + 20'(k * 16));
    do_look("R8 evict first", 20'h00002, 1'b0, 20'h0);
    do_look("R8 evict second", 20'h00012, 1'b0, 20'h0);
    do_look("R8 kept", 20'h00022, 1'b1, 20'h00122);
    do_look("R8 new", 20'h00052, 1'b1, 20'h00152);
    do_fill(20'h00022, 20'h77777);  // rewrite in place, pointer still at way 2
    do_look("R8 rewrite", 20'h00022, 1'b1, 20'h77777);
    do_look("R8 no evict", 20'h00032, 1'b1, 20'h00132);
    do_fill(20'h00062, 20'h00162);  // evicts way 2 (holds 0x022)
    do_look("R8 rr third", 20'h00022, 1'b0, 20'h0);
    do_look("R8 rr keep", 20'h00032, 1'b1, 20'h00132);

    // R9: same-cycle interactions
    req_valid = 1; req_vpn = 20'h00032; inv_en = 1; inv_op = 2'b00; inv_vpn = 20'h00032; inv_ctx = 12'h005;
    tick(); clear_in();
    chk_rsp("R9 inv first", 1'b0, 20'h0);
    req_valid = 1; req_vpn = 20'h00042; fill_en = 1; fill_vpn = 20'h00042; fill_pfn = 20'h99999;
    tick(); clear_in();
    chk_rsp("R9 fill after", 1'b1, 20'h00142);
    do_look("R9 fill seen", 20'h00042, 1'b1, 20'h99999);
    req_valid = 1; req_vpn = 20'h00052; ctx_load = 1; ctx_keep = 1; ctx_sel = 12'h009;
    tick(); clear_in();
    chk_rsp("R9 ctx first", 1'b0, 20'h0);
    ctx_load = 1; ctx_keep = 1; ctx_sel = 12'h005;
    tick(); clear_in();
    do_look("R9 ctx back", 20'h00052, 1'b1, 20'h00152);

    // R10: back-pressure
    rsp_ready = 0; req_valid = 1; req_vpn = 20'h00052;
    tick();
    chk("R10 valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 ready low", {31'b0, req_ready}, 32'd0);
    req_vpn = 20'h00062;
    tick();
    chk("R10 hold pfn", {12'b0, rsp_pfn}, 32'h00152);
    chk("R10 hold valid", {31'b0, rsp_valid}, 32'd1);
    rsp_ready = 1;
    tick();
    chk_rsp("R10 next", 1'b1, 20'h00162);
    req_valid = 0;
    tick();
    chk("R10 drained", {31'b0, rsp_valid}, 32'd0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule